// File: doc/BRIEF.md
# Single-Bit Manipulation Execute Unit

This unit decodes and executes the four single-bit operations of a RISC-V integer pipeline: clear one bit, extract one bit, invert one bit and set one bit. Each operation comes in two forms. The register form takes the bit index from the second source operand. The immediate form carries the bit index in the instruction word. The unit receives a 32-bit instruction word with a valid strobe and the two source operand values. One clock edge later it presents the result, the destination register index, a write enable and an illegal-instruction flag.

The datapath width is set by the parameter `XLEN`, which is either 32 or 64. The bit index is cut down to the width that addresses one bit of the datapath. On a 32-bit datapath, an immediate-form word whose sixth index bit is set is not a valid instruction. The unit only reports words it does not recognise. Fetch, register-file access and trap handling are done by the surrounding pipeline.

Top module: `bitop_exec_unit`

## Requirements
- R1: A word with opcode bits [6:0] = 0110011 is decoded as a register-form operation. The operation is selected by funct3 bits [14:12] and funct7 bits [31:25]: clear is funct3 001 with funct7 0100100, extract is funct3 101 with funct7 0100100, invert is funct3 001 with funct7 0110100, and set is funct3 001 with funct7 0010100.
- R2: A word with opcode 0010011 is decoded as an immediate-form operation. The operation is selected by bits [31:26] and funct3: clear is 010010 with 001, extract is 010010 with 101, invert is 011010 with 001, and set is 001010 with 001. The bit index is taken from bits [25:20].
- R3: When XLEN is 32, an immediate-form word with bit 25 set is flagged illegal. When XLEN is 64, the same word is legal.
- R4: The bit index is the low 5 bits of rs2 (or of the immediate) when XLEN is 32, and the low 6 bits when XLEN is 64. Higher bits are ignored.
- R5: Clear returns rs1 with the indexed bit forced to 0.
- R6: Invert returns rs1 with the indexed bit flipped.
- R7: Set returns rs1 with the indexed bit forced to 1.
- R8: Extract returns 1 in bit 0 when the indexed bit of rs1 is 1, and 0 otherwise. All higher result bits are 0.
- R9: A valid word that matches none of the eight encodings raises the illegal flag for one cycle. The write enable stays low and the result is 0.
- R10: The destination index output is bits [11:7] of the instruction word. The write enable is low when that index is 0, and the illegal flag is not raised for that reason.
- R11: All outputs appear exactly one cycle after the input is accepted. Output valid follows input valid with one cycle of delay. Reset clears output valid, write enable and the illegal flag.
- R12: Write enable and the illegal flag are never high together, and neither is high while output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are valid |
| in_instr | input | 32 | Instruction word |
| in_rs1 | input | XLEN | First source operand value |
| in_rs2 | input | XLEN | Second source operand value (supplies the bit index in register form) |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | XLEN | Operation result (0 for an illegal word) |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Register-file write enable |
| out_illegal | output | 1 | Word was not recognised |

## Verification
Each of the eight encodings is driven with an index that has high bits set above the legal range. This separates 5-bit index truncation from 6-bit index truncation, and it also separates the register-form index source from the immediate-form one. An immediate word with index bit 5 set is sent to a 32-bit and a 64-bit instance at the same time, so the legality check is shown to depend on the width. Near-miss words with one wrong field (funct7, funct3, top six bits or opcode) show that every field is matched exactly. Extract is tried with the indexed bit both set and clear, and the destination index 0 is tried to show that the write is suppressed without raising the illegal flag. Random legal and random arbitrary words then cover operand values across both widths.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    BOP_CLR = 2'd0,
    BOP_EXT = 2'd1,
    BOP_INV = 2'd2,
    BOP_SET = 2'd3
  } bop_e;

  typedef struct packed {
    logic legal;
    logic use_imm;
    bop_e op;
  } bop_dec_t;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [2:0] F3_MOD  = 3'b001;
  localparam logic [2:0] F3_EXT  = 3'b101;
  localparam logic [6:0] F7_CLR  = 7'b0100100;
  localparam logic [6:0] F7_INV  = 7'b0110100;
  localparam logic [6:0] F7_SET  = 7'b0010100;
  localparam logic [5:0] T6_CLR  = 6'b010010;
  localparam logic [5:0] T6_INV  = 6'b011010;
  localparam logic [5:0] T6_SET  = 6'b001010;

endpackage

// File: rtl/bitop_decoder.sv
module bitop_decoder
  import bitop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output bop_dec_t   dec
);

  logic [5:0] top6;
  logic       reg_hit;
  logic       imm_hit;
  logic       imm_idx_ok;
  bop_e       reg_op;
  bop_e       imm_op;

  assign top6 = funct7[6:1];

  // The sixth index bit is only meaningful on a 64-bit datapath.
  generate
    if (XLEN == 32) begin : g_idx32
      assign imm_idx_ok = ~funct7[0];
    end else begin : g_idx64
      assign imm_idx_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    reg_hit = 1'b0;
    reg_op  = BOP_CLR;
    if (opcode == OPC_REG) begin
      if (funct3 == F3_MOD) begin
        unique case (funct7)
          F7_CLR:  begin reg_hit = 1'b1; reg_op = BOP_CLR; end
          F7_INV:  begin reg_hit = 1'b1; reg_op = BOP_INV; end
          F7_SET:  begin reg_hit = 1'b1; reg_op = BOP_SET; end
          default: reg_hit = 1'b0;
        endcase
      end else if (funct3 == F3_EXT && funct7 == F7_CLR) begin
        reg_hit = 1'b1;
        reg_op  = BOP_EXT;
      end
    end
  end

  always_comb begin
    imm_hit = 1'b0;
    imm_op  = BOP_CLR;
    if (opcode == OPC_IMM) begin
      if (funct3 == F3_MOD) begin
        unique case (top6)
          T6_CLR:  begin imm_hit = 1'b1; imm_op = BOP_CLR; end
          T6_INV:  begin imm_hit = 1'b1; imm_op = BOP_INV; end
          T6_SET:  begin imm_hit = 1'b1; imm_op = BOP_SET; end
          default: imm_hit = 1'b0;
        endcase
      end else if (funct3 == F3_EXT && top6 == T6_CLR) begin
        imm_hit = 1'b1;
        imm_op  = BOP_EXT;
      end
    end
  end

  always_comb begin
    dec.use_imm = (opcode == OPC_IMM);
    dec.legal   = reg_hit | (imm_hit & imm_idx_ok);
    dec.op      = dec.use_imm ? imm_op : reg_op;
  end

  // R3: a narrow datapath never accepts an immediate index of 32 or more
  always_comb begin
    if (XLEN == 32 && opcode == OPC_IMM && funct7[0]) begin
      assert_imm_idx_R3: assert (!dec.legal)
        else $error("R3 immediate index bit 5 accepted on 32-bit datapath");
    end
  end

endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
  import bitop_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = $clog2(XLEN)
) (
  input  bop_e             op,
  input  logic             use_imm,
  input  logic [IDX_W-1:0] imm_idx,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [XLEN-1:0]  rs1,
  output logic [XLEN-1:0]  res
);

  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  mask;
  logic             hit;

  assign idx  = use_imm ? imm_idx : reg_idx;
  assign mask = {{(XLEN-1){1'b0}}, 1'b1} << idx;
  assign hit  = |(rs1 & mask);

  always_comb begin
    unique case (op)
      BOP_CLR: res = rs1 & ~mask;
      BOP_EXT: res = {{(XLEN-1){1'b0}}, hit};
      BOP_INV: res = rs1 ^ mask;
      default: res = rs1 | mask;
    endcase
  end

  // R5 R6 R7: modifying operations touch at most one bit of rs1
  // R8: extract leaves every bit above bit 0 clear
  always_comb begin
    if (op != BOP_EXT) begin
      assert_single_bit_R5: assert ($onehot0(res ^ rs1))
        else $error("R5 more than one bit changed");
    end else begin
      assert_ext_upper_R8: assert (res[XLEN-1:1] == '0)
        else $error("R8 extract upper bits nonzero");
    end
  end

endmodule

// File: rtl/bitop_out_reg.sv
module bitop_out_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            legal,
  input  logic [4:0]      rd_idx,
  input  logic [XLEN-1:0] res,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic [4:0]      out_rd,
  output logic            out_wen,
  output logic            out_illegal
);

  logic            valid_d;
  logic            wen_d;
  logic            ill_d;
  logic            data_en;
  logic [XLEN-1:0] result_d;

  always_comb begin
    valid_d  = in_valid;
    wen_d    = in_valid & legal & (rd_idx != 5'd0);
    ill_d    = in_valid & ~legal;
    data_en  = in_valid;
    result_d = legal ? res : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_wen     <= wen_d;
      out_illegal <= ill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      out_result <= result_d;
      out_rd     <= rd_idx;
    end
  end

  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("R11 output valid missing");

  assert_idle_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid)
    else $error("R11 output valid without input");

  assert_rd_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_rd == $past(rd_idx))
    else $error("R10 destination index not carried");

  assert_rd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_rd != 5'd0)
    else $error("R10 write to index 0");

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_wen && out_illegal))
    else $error("R12 write enable with illegal");

  assert_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wen || out_illegal) |-> out_valid)
    else $error("R12 strobe without valid");

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_result == '0)
    else $error("R9 illegal result nonzero");

endmodule

// File: rtl/bitop_exec_unit.sv
module bitop_exec_unit
  import bitop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic [4:0]      out_rd,
  output logic            out_wen,
  output logic            out_illegal
);

  localparam int IDX_W = $clog2(XLEN);

  bop_dec_t        dec;
  logic [XLEN-1:0] res;
  logic            unused_bits;

  assign unused_bits = ^{in_instr[19:15], in_rs2[XLEN-1:IDX_W]};

  bitop_decoder #(.XLEN(XLEN)) u_dec (
    .opcode (in_instr[6:0]),
    .funct3 (in_instr[14:12]),
    .funct7 (in_instr[31:25]),
    .dec    (dec)
  );

  bitop_datapath #(.XLEN(XLEN), .IDX_W(IDX_W)) u_dp (
    .op      (dec.op),
    .use_imm (dec.use_imm),
    .imm_idx (in_instr[20 +: IDX_W]),
    .reg_idx (in_rs2[IDX_W-1:0]),
    .rs1     (in_rs1),
    .res     (res)
  );

  bitop_out_reg #(.XLEN(XLEN)) u_oreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .legal       (dec.legal),
    .rd_idx      (in_instr[11:7]),
    .res         (res),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_rd      (out_rd),
    .out_wen     (out_wen),
    .out_illegal (out_illegal)
  );

endmodule

// File: tb/sim_bitop_exec_unit.sv
module sim_bitop_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_instr;
  logic [63:0] in_rs1;
  logic [63:0] in_rs2;

  logic        v64, w64, i64, v32, w32, i32;
  logic [63:0] r64;
  logic [31:0] r32;
  logic [4:0]  d64, d32;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bitop_exec_unit #(.XLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_rs1(in_rs1), .in_rs2(in_rs2),
    .out_valid(v64), .out_result(r64), .out_rd(d64), .out_wen(w64), .out_illegal(i64)
  );

  bitop_exec_unit #(.XLEN(32)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_rs1(in_rs1[31:0]), .in_rs2(in_rs2[31:0]),
    .out_valid(v32), .out_result(r32), .out_rd(d32), .out_wen(w32), .out_illegal(i32)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op: 0 clear, 1 extract, 2 invert, 3 set
  function automatic logic [6:0] f7_of(input int op);
    case (op)
      2:       return 7'b0110100;
      3:       return 7'b0010100;
      default: return 7'b0100100;
    endcase
  endfunction

  function automatic logic [31:0] mk_reg(input int op, input logic [4:0] rd);
    return {f7_of(op), 5'd3, 5'd2, (op == 1) ? 3'b101 : 3'b001, rd, 7'b0110011};
  endfunction

  function automatic logic [31:0] mk_imm(input int op, input logic [5:0] sh, input logic [4:0] rd);
    logic [6:0] f7 = f7_of(op);
    return {f7[6:1], sh, 5'd2, (op == 1) ? 3'b101 : 3'b001, rd, 7'b0010011};
  endfunction

  // returns {legal, result}
  function automatic logic [64:0] model(input int xl, input logic [31:0] ins,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [6:0]  opc = ins[6:0];
    logic [2:0]  f3  = ins[14:12];
    logic [6:0]  f7  = ins[31:25];
    logic        legal = 1'b0;
    logic        imm   = 1'b0;
    int          op    = 0;
    logic [5:0]  idx;
    logic [63:0] m, av, r;
    if (opc == 7'b0110011) begin
      if (f3 == 3'b001 && f7 == 7'b0100100) begin legal = 1; op = 0; end
      else if (f3 == 3'b101 && f7 == 7'b0100100) begin legal = 1; op = 1; end
      else if (f3 == 3'b001 && f7 == 7'b0110100) begin legal = 1; op = 2; end
      else if (f3 == 3'b001 && f7 == 7'b0010100) begin legal = 1; op = 3; end
    end else if (opc == 7'b0010011) begin
      imm = 1;
      if (f3 == 3'b001 && f7[6:1] == 6'b010010) begin legal = 1; op = 0; end
      else if (f3 == 3'b101 && f7[6:1] == 6'b010010) begin legal = 1; op = 1; end
      else if (f3 == 3'b001 && f7[6:1] == 6'b011010) begin legal = 1; op = 2; end
      else if (f3 == 3'b001 && f7[6:1] == 6'b001010) begin legal = 1; op = 3; end
      if (xl == 32 && ins[25]) legal = 0;
    end
    idx = imm ? ins[25:20] : b[5:0];
    if (xl == 32) idx[5] = 1'b0;
    av = (xl == 32) ? {32'b0, a[31:0]} : a;
    m  = 64'd1 << idx;
    case (op)
      0:       r = av & ~m;
      1:       r = {63'b0, |(av & m)};
      2:       r = av ^ m;
      default: r = av | m;
    endcase
    if (xl == 32) r[63:32] = '0;
    if (!legal) r = '0;
    return {legal, r};
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic send(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [64:0] e64, e32;
    logic [4:0]  rd = ins[11:7];
    e64 = model(64, ins, a, b);
    e32 = model(32, ins, a, b);
    in_valid = 1'b1; in_instr = ins; in_rs1 = a; in_rs2 = b;
    @(negedge clk);
    chk(v64 && v32, {tag, " R11 valid"}, {62'b0, v32, v64}, 64'd3);
    chk(i64 == !e64[64], {tag, " R9 illegal x64"}, {63'b0, i64}, {63'b0, !e64[64]});
    chk(i32 == !e32[64], {tag, " R3 illegal x32"}, {63'b0, i32}, {63'b0, !e32[64]});
    chk(w64 == (e64[64] && rd != 0), {tag, " R10 wen x64"}, {63'b0, w64}, {63'b0, e64[64] && rd != 0});
    chk(w32 == (e32[64] && rd != 0), {tag, " R10 wen x32"}, {63'b0, w32}, {63'b0, e32[64] && rd != 0});
    chk(d64 == rd && d32 == rd, {tag, " R10 rd"}, {54'b0, d32, d64}, {54'b0, rd, rd});
    chk(r64 == e64[63:0], {tag, " result x64"}, r64, e64[63:0]);
    chk(r32 == e32[31:0], {tag, " R4 result x32"}, {32'b0, r32}, e32[63:0]);
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0; in_instr = $urandom;
    @(negedge clk);
    chk(!v64 && !v32 && !w64 && !w32 && !i64 && !i32, {tag, " R11 idle"},
        {58'b0, v64, v32, w64, w32, i64, i32}, 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] pat;
    void'($urandom(32'd20240611));
    pat = 64'hF0F0_A5A5_0F0F_5A5A;
    rst_n = 1'b0; in_valid = 1'b1; in_instr = mk_reg(3, 5'd1); in_rs1 = '0; in_rs2 = '0;
    repeat (3) @(negedge clk);
    chk(!v64 && !v32 && !w64 && !i64, "R11 reset state",
        {60'b0, v64, v32, w64, i64}, 64'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);

    // R1 register forms, index 0x27: bit 39 on 64-bit, bit 7 on 32-bit (R4)
    for (int op = 0; op < 4; op++) send(mk_reg(op, 5'd5), pat, 64'hFFFF_FFFF_FFFF_FFE7, "R1 reg");
    for (int op = 0; op < 4; op++) send(mk_reg(op, 5'd9), ~pat, 64'd63, "R1 reg top");
    // R2 immediate forms, index 0x13 (legal on both widths)
    for (int op = 0; op < 4; op++) send(mk_imm(op, 6'h13, 5'd7), pat, 64'h0, "R2 imm");
    // R3 index bit 5 set: legal on 64-bit, illegal on 32-bit
    for (int op = 0; op < 4; op++) send(mk_imm(op, 6'h27, 5'd8), pat, 64'h0, "R3 imm hi");
    // R5 R6 R7 on all-ones and all-zeros operands
    send(mk_reg(0, 5'd1), '1, 64'd0, "R5 clear bit0");
    send(mk_reg(2, 5'd1), '0, 64'd31, "R6 invert bit31");
    send(mk_reg(3, 5'd1), '0, 64'd32, "R7 set bit32");
    // R8 extract set and clear bit
    send(mk_reg(1, 5'd4), 64'h8000_0000_0000_0000, 64'd63, "R8 extract one");
    send(mk_reg(1, 5'd4), 64'h7FFF_FFFF_FFFF_FFFF, 64'd63, "R8 extract zero");
    send(mk_imm(1, 6'd0, 5'd4), 64'd1, 64'd0, "R8 extract imm");
    // R9 near misses
    send({7'b0100000, 5'd3, 5'd2, 3'b001, 5'd6, 7'b0110011}, pat, 64'd3, "R9 bad funct7");
    send({7'b0100100, 5'd3, 5'd2, 3'b011, 5'd6, 7'b0110011}, pat, 64'd3, "R9 bad funct3");
    send({6'b010011, 6'd2, 5'd2, 3'b001, 5'd6, 7'b0010011}, pat, 64'd3, "R9 bad top6");
    send({7'b0010100, 5'd3, 5'd2, 3'b001, 5'd6, 7'b0111011}, pat, 64'd3, "R9 bad opcode");
    send({7'b0110100, 5'd3, 5'd2, 3'b101, 5'd6, 7'b0110011}, pat, 64'd3, "R9 invert funct3 101");
    // R10 destination zero
    send(mk_reg(3, 5'd0), pat, 64'd2, "R10 rd zero");
    send(mk_imm(2, 6'd2, 5'd0), pat, 64'd0, "R10 rd zero imm");
    // R11 idle gap and back-to-back
    idle("R11 gap");
    send(mk_reg(2, 5'd31), pat, 64'd10, "R11 after gap");
    idle("R11 gap2");

    for (int i = 0; i < 600; i++) begin
      int kind = $urandom_range(0, 11);
      logic [31:0] ins;
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [4:0]  rd = (kind == 0) ? 5'd0 : 5'($urandom);
      if (kind < 4) ins = mk_reg(kind, rd);
      else if (kind < 8) ins = mk_imm(kind - 4, 6'($urandom), rd);
      else if (kind < 10) ins = $urandom;
      else ins = mk_reg(kind - 8, rd) ^ (32'd1 << $urandom_range(12, 31));
      send(ins, a, b, "random");
      if ($urandom_range(0, 7) == 0) idle("random R11");
    end

    finish_run();
  end

endmodule